// File: doc/BRIEF.md
# Calendar Alarm Match Unit

This block watches the running calendar of a real-time clock and raises an alarm when the time reaches a programmed point. It holds six alarm bytes: seconds, minutes, hours, weekday, day of month and month. Each byte carries its own compare enable, so software can build alarms such as "every day at 07:30:00" or "every minute at second 15" by leaving the unwanted fields disabled. The year is never part of the match.

The calendar counter presents its BCD fields together with a one-cycle strobe in the cycle after it has advanced. On that strobe, and only then, the block compares every enabled field against the current time. If all enabled fields match, it latches a sticky alarm flag. An interrupt line follows the flag when the alarm interrupt enable is set. Software reads and writes the alarm bytes and one control byte through a simple register port. It clears the flag by writing 0 to the flag bit.

Top module: `rtc_alarm_cmp`

## Requirements
- R1: After reset all six alarm bytes read 0x00, and the flag, the interrupt enable and `alarm_irq` are 0.
- R2: The alarm bytes live at register indices 8 to 13 in this order: seconds, minutes, hours, weekday, day of month, month. A write stores the whole byte and a read returns it unchanged.
- R3: The control byte is at index 14, with the alarm flag in bit 0 and the interrupt enable in bit 3. Its other bits, and every index outside 8 to 14, read as 0.
- R4: Bit 7 of an alarm byte enables the compare of that field against bits 6:0. A field whose bit 7 is 0 takes no part in the match, whatever its target and the current value hold.
- R5: On a `sec_tick` cycle the flag is set in the next cycle when every enabled field equals its current time field. A mismatch in any one enabled field leaves the flag unchanged.
- R6: When no field has its enable bit set, a tick never sets the flag.
- R7: The flag is set only by a tick. A matching time without `sec_tick` does not set it.
- R8: Writing the control byte with bit 0 at 0 clears the flag. Writing it with bit 0 at 1 leaves the flag as it was and never sets it.
- R9: `alarm_irq` is high exactly when both the flag and the interrupt enable are 1.
- R10: When a matching tick and a write that clears the flag fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle strobe issued after the calendar fields have advanced |
| cur_sec | input | 7 | Current seconds, BCD |
| cur_min | input | 7 | Current minutes, BCD |
| cur_hour | input | 7 | Current hours, BCD |
| cur_wday | input | 7 | Current weekday |
| cur_mday | input | 7 | Current day of month, BCD |
| cur_mon | input | 7 | Current month, BCD |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index for read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| alarm_flag | output | 1 | Sticky alarm flag |
| alarm_irq | output | 1 | Alarm interrupt request |

## Verification
The match is tried with four kinds of alarm setup. In the first, every field is disabled; this separates a correct "no alarm" from one that treats an empty set as a match. In the second, only seconds are enabled while the other fields hold mismatched values; this shows that disabled fields really are don't-care. In the third, all six fields are enabled and one field is off by a single unit; this confirms that every enabled field is needed for the match. In the fourth, a disabled byte holds a nonzero target that conflicts with the time, which separates the enable bit from a test on a zero value. The tests also cover a match without a tick, a tick that coincides with a clearing write, and writes of 1 to the flag bit.

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp #(
  parameter int FW       = 7,
  parameter int AW       = 4,
  parameter int DW       = 8,
  parameter int BASE     = 8,
  parameter int CTRL     = 14,
  parameter int FLAG_BIT = 0,
  parameter int AIE_BIT  = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sec_tick,
  input  logic [FW-1:0] cur_sec,
  input  logic [FW-1:0] cur_min,
  input  logic [FW-1:0] cur_hour,
  input  logic [FW-1:0] cur_wday,
  input  logic [FW-1:0] cur_mday,
  input  logic [FW-1:0] cur_mon,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          alarm_flag,
  output logic          alarm_irq
);
  localparam int NF     = 6;
  localparam int EN_BIT = DW - 1;

  logic [DW-1:0] alm_q [NF];
  logic [FW-1:0] now   [NF];
  logic [NF-1:0] fld_en, fld_eq;
  logic          hit, ctrl_wr, aie_q;

  assign now[0] = cur_sec;
  assign now[1] = cur_min;
  assign now[2] = cur_hour;
  assign now[3] = cur_wday;
  assign now[4] = cur_mday;
  assign now[5] = cur_mon;

  for (genvar i = 0; i < NF; i++) begin : g_fld
    always_ff @(posedge clk)
      if (!rst_n)
        alm_q[i] <= '0;
      else if (reg_wr && reg_addr == AW'(BASE + i))
        alm_q[i] <= reg_wdata;
    assign fld_en[i] = alm_q[i][EN_BIT];
    assign fld_eq[i] = (alm_q[i][FW-1:0] == now[i]);
  end

  assign hit     = (|fld_en) && (&(fld_eq | ~fld_en));
  assign ctrl_wr = reg_wr && reg_addr == AW'(CTRL);

  always_ff @(posedge clk)
    if (!rst_n) begin
      alarm_flag <= 1'b0;
      aie_q      <= 1'b0;
    end else begin
      if (sec_tick && hit)
        alarm_flag <= 1'b1;
      else if (ctrl_wr && !reg_wdata[FLAG_BIT])
        alarm_flag <= 1'b0;
      if (ctrl_wr)
        aie_q <= reg_wdata[AIE_BIT];
    end

  assign alarm_irq = alarm_flag & aie_q;

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NF; i++)
      if (reg_addr == AW'(BASE + i))
        reg_rdata = alm_q[i];
    if (reg_addr == AW'(CTRL)) begin
      reg_rdata[FLAG_BIT] = alarm_flag;
      reg_rdata[AIE_BIT]  = aie_q;
    end
  end

  assert_set_on_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && hit) |=> alarm_flag);
  assert_rise_needs_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_flag) |-> $past(sec_tick));
  assert_empty_never_fires_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && fld_en == '0 && !alarm_flag) |=> !alarm_flag);
  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !reg_wdata[FLAG_BIT] && !sec_tick) |=> !alarm_flag);
  assert_write_one_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && reg_wdata[FLAG_BIT] && alarm_flag) |=> alarm_flag);
  assert_irq_needs_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_irq |-> (alarm_flag && aie_q));
  assert_tick_beats_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && hit && ctrl_wr) |=> alarm_flag);
endmodule

// File: tb/rtc_alarm_cmp_bench.sv
module rtc_alarm_cmp_bench;
  logic clk = 1'b0, rst_n = 1'b0, sec_tick = 1'b0, reg_wr = 1'b0;
  logic [6:0] t_sec = '0, t_min = '0, t_hour = '0, t_wday = '0, t_mday = '0, t_mon = '0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic alarm_flag, alarm_irq;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rtc_alarm_cmp u_rtc_alarm_cmp (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
    .cur_sec(t_sec), .cur_min(t_min), .cur_hour(t_hour),
    .cur_wday(t_wday), .cur_mday(t_mday), .cur_mon(t_mon),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .alarm_flag(alarm_flag), .alarm_irq(alarm_irq));

  typedef struct {
    logic [7:0] rd;
    logic       fl;
    logic       ir;
    string      tag;
  } item_t;
  item_t sb[$];

  task automatic expect_state(input logic [3:0] a, input logic [7:0] rd,
                              input logic fl, input logic ir, input string tag);
    item_t it;
    @(negedge clk);
    reg_addr = a; reg_wr = 1'b0; sec_tick = 1'b0;
    it.rd = rd; it.fl = fl; it.ir = ir; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic step(input logic tk, input logic wr, input logic [3:0] a,
                      input logic [7:0] d);
    @(negedge clk);
    sec_tick = tk; reg_wr = wr; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    sec_tick = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    step(1'b0, 1'b1, a, d);
  endtask

  task automatic tick();
    step(1'b1, 1'b0, 4'd0, 8'h00);
  endtask

  task automatic set_time(input logic [6:0] s, mi, h, w, dm, mo);
    t_sec = s; t_min = mi; t_hour = h; t_wday = w; t_mday = dm; t_mon = mo;
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(negedge clk);
      #5;
      while (sb.size() > 0) begin
        it = sb.pop_front();
        total++;
        if (reg_rdata !== it.rd || alarm_flag !== it.fl || alarm_irq !== it.ir) begin
          bad++;
          $display("FAIL %s: rd=%02h flag=%b irq=%b expected rd=%02h flag=%b irq=%b",
                   it.tag, reg_rdata, alarm_flag, alarm_irq, it.rd, it.fl, it.ir);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int i = 8; i < 14; i++) expect_state(4'(i), 8'h00, 0, 0, "R1 alarm byte reset");
    expect_state(4'd14, 8'h00, 0, 0, "R1 control reset");
    // R2 readback in index order sec,min,hour,wday,mday,mon
    for (int i = 0; i < 6; i++) wr(4'(8 + i), 8'(8'h11 * (i + 1) + 8'h80 * (i % 2)));
    for (int i = 0; i < 6; i++)
      expect_state(4'(8 + i), 8'(8'h11 * (i + 1) + 8'h80 * (i % 2)), 0, 0, "R2 readback");
    // R3 unmapped indices and unused control bits
    expect_state(4'd15, 8'h00, 0, 0, "R3 index 15 reads 0");
    expect_state(4'd0, 8'h00, 0, 0, "R3 index 0 reads 0");
    wr(4'd14, 8'hF6);
    expect_state(4'd14, 8'h00, 0, 0, "R3 control unused bits read 0");
    // R6 no field enabled
    for (int i = 8; i < 14; i++) wr(4'(i), 8'h00);
    set_time(7'h00, 7'h00, 7'h00, 7'h00, 7'h00, 7'h00);
    tick();
    expect_state(4'd14, 8'h00, 0, 0, "R6 all-zero bytes never fire");
    // R7 match without tick; only seconds enabled, others hold mismatching targets
    wr(4'd8, 8'hB0);
    wr(4'd9, 8'h12); wr(4'd10, 8'h05);
    set_time(7'h30, 7'h44, 7'h21, 7'h03, 7'h17, 7'h09);
    repeat (4) @(negedge clk);
    expect_state(4'd14, 8'h00, 0, 0, "R7 no tick no set");
    // R4/R5 seconds-only alarm fires on tick
    tick();
    expect_state(4'd14, 8'h01, 1, 0, "R4 R5 seconds-only match");
    // R9 irq masked while enable is 0; R8 write 1 keeps flag
    expect_state(4'd14, 8'h01, 1, 0, "R9 irq low with enable 0");
    wr(4'd14, 8'h09);
    expect_state(4'd14, 8'h09, 1, 1, "R8 R9 write 1 keeps flag, irq high");
    wr(4'd14, 8'h08);
    expect_state(4'd14, 8'h08, 0, 0, "R8 write 0 clears flag");
    wr(4'd14, 8'h09);
    expect_state(4'd14, 8'h08, 0, 0, "R8 write 1 never sets flag");
    // R5 all fields enabled, one off by one
    wr(4'd8, 8'hB0); wr(4'd9, 8'hC4); wr(4'd10, 8'hA1);
    wr(4'd11, 8'h83); wr(4'd12, 8'h97); wr(4'd13, 8'h89);
    set_time(7'h30, 7'h44, 7'h21, 7'h03, 7'h17, 7'h08);
    tick();
    expect_state(4'd14, 8'h08, 0, 0, "R5 month mismatch blocks");
    set_time(7'h31, 7'h44, 7'h21, 7'h03, 7'h17, 7'h09);
    tick();
    expect_state(4'd14, 8'h08, 0, 0, "R5 seconds mismatch blocks");
    set_time(7'h30, 7'h44, 7'h21, 7'h03, 7'h17, 7'h09);
    tick();
    expect_state(4'd14, 8'h09, 1, 1, "R5 full match fires");
    // R4 disabled minute byte with conflicting nonzero target
    wr(4'd14, 8'h08);
    wr(4'd9, 8'h15);
    tick();
    expect_state(4'd14, 8'h09, 1, 1, "R4 disabled field ignored");
    expect_state(4'd9, 8'h15, 1, 1, "R2 minute byte intact");
    // R10 tick and clearing write in the same cycle
    wr(4'd14, 8'h08);
    expect_state(4'd14, 8'h08, 0, 0, "R10 precondition flag clear");
    step(1'b1, 1'b1, 4'd14, 8'h08);
    expect_state(4'd14, 8'h09, 1, 1, "R10 set wins over clear");
    // R9 disable interrupt with flag held
    wr(4'd14, 8'h01);
    expect_state(4'd14, 8'h01, 1, 0, "R9 irq drops with enable 0");
    repeat (3) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule